// File: doc/BRIEF.md
# Serial Segment-Display Command Interface

This block is the host-facing front end of a segment display controller. A host shifts 8-bit frames into it over a four-wire clocked serial link made of an active-low select, a serial clock, a serial data line and a command/data flag. All four pins are asynchronous to the system clock. They pass through two-flop synchronisers, and serial clock edges are detected in the system clock domain. The level of the command/data flag at the eighth rising serial clock edge of a frame decides what the frame is. When the flag is high, the byte is decoded as a command. When it is low, the byte is two nibbles of display data.

Commands can load a 5-bit address pointer, write a single nibble, select one of three display modes, or clear the pointer and blank the display. Display data lands in an 18-entry by 4-bit store. A display scanner reads that store through a combinational read port and also reads the current display mode. The pointer advances by two after a data byte and by one after a nibble-write command. Increments wrap from the last entry back to entry zero.

Top module: `seg_cmd_if`

## Requirements
- R1: After the reset input is released, `disp_mode` is 2'b00 (display off), every store entry reads 0, and the address pointer is 0.
- R2: A frame is 8 bits, most significant bit first. Each bit is taken on a rising serial clock edge while select is low. The command/data flag is sampled at the eighth rising edge: 1 means command, 0 means display data. A frame changes no state until its eighth edge.
- R3: A command whose bits [7:5] are 000 loads bits [4:0] into the address pointer.
- R4: A display-data byte writes bits [7:4] to the entry at the pointer and bits [3:0] to the entry after it, then advances the pointer twice.
- R5: A command whose bits [7:5] are 100 writes its bits [3:0] to the entry at the pointer and advances the pointer once.
- R6: Advancing the pointer from 17 gives 0. A data byte written at pointer 17 puts its low nibble in entry 0 and leaves the pointer at 1.
- R7: Command bits [7:5] select the display mode: 001 gives all lit (`disp_mode` 2'b01), 010 gives all dark (2'b00), and 011 makes the display follow the store (2'b10). These commands leave the store unchanged.
- R8: Command bits [7:5] = 110 sets `disp_mode` to 2'b00 and the pointer to 0, and leaves the store unchanged.
- R9: Commands with bits [7:5] equal to 101 or 111 change neither the mode, the pointer nor the store.
- R10: If select rises before a frame's eighth bit, the bits received so far are discarded, and the next frame starts from its first bit.
- R11: `rd_nib` shows the entry addressed by `rd_addr` when `rd_addr` is below 18, and 0 otherwise. Writes to pointer values of 18 or more are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_csn | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock, bits taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_cd | input | 1 | Command (1) / display data (0) flag |
| rd_addr | input | 5 | Scanner read address |
| rd_nib | output | 4 | Scanner read data |
| disp_mode | output | 2 | 00 off, 01 all lit, 10 follow store |

## Verification
Directed frames first cover the pointer at 16 and at 17. These cases separate a correct wrap from a pointer that runs past the last entry, and a two-step data advance from a one-step one. Ignored opcodes, mode commands and the clear command are each followed by a nibble write. The entry that write lands in shows whether the pointer moved when it should not have. A frame cut short by select is followed by a full frame, which catches a receiver that keeps stale bits. Seeded random mixes of every frame type are then compared with a bench model of the whole store and the display mode.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned FRAME_W = 8;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned DEPTH   = 18;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_ALL = 2'b01,
    MODE_RAM = 2'b10
  } disp_mode_e;

  typedef enum logic [2:0] {
    OP_PTR  = 3'b000,
    OP_LIT  = 3'b001,
    OP_DARK = 3'b010,
    OP_RUN  = 3'b011,
    OP_NIB  = 3'b100,
    OP_NOP5 = 3'b101,
    OP_CLR  = 3'b110,
    OP_NOP7 = 3'b111
  } op_e;

  function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(DEPTH - 1)) return '0;
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/seg_sync.sv
module seg_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/seg_rx.sv
module seg_rx
  import seg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csn_i,
  input  logic               sck_i,
  input  logic               sdi_i,
  input  logic               cd_i,
  output logic               frm_vld_o,
  output logic               frm_cmd_o,
  output logic [FRAME_W-1:0] frm_byte_o,
  output logic [CNT_W-1:0]   bit_cnt_o
);
  logic               sck_q;
  logic [FRAME_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               vld_q, vld_d;
  logic               cmd_q, cmd_d;
  logic [FRAME_W-1:0] byte_q, byte_d;
  logic               sck_rise;
  logic [FRAME_W-1:0] shifted;

  assign sck_rise = sck_i & ~sck_q;
  assign shifted  = {shift_q[FRAME_W-2:0], sdi_i};

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    vld_d   = 1'b0;
    cmd_d   = cmd_q;
    byte_d  = byte_q;
    if (csn_i) begin
      cnt_d = '0;
    end else if (sck_rise) begin
      shift_d = shifted;
      if (cnt_q == CNT_W'(FRAME_W - 1)) begin
        cnt_d  = '0;
        vld_d  = 1'b1;
        byte_d = shifted;
        cmd_d  = cd_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
      cmd_q   <= 1'b0;
      byte_q  <= '0;
    end else begin
      sck_q   <= sck_i;
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
      cmd_q   <= cmd_d;
      byte_q  <= byte_d;
    end
  end

  assign frm_vld_o  = vld_q;
  assign frm_cmd_o  = cmd_q;
  assign frm_byte_o = byte_q;
  assign bit_cnt_o  = cnt_q;
endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_vld_i,
  input  logic               frm_cmd_i,
  input  logic [FRAME_W-1:0] frm_byte_i,
  output logic [ADDR_W-1:0]  ptr_o,
  output disp_mode_e         mode_o,
  output logic               we0_o,
  output logic [ADDR_W-1:0]  wa0_o,
  output logic [NIB_W-1:0]   wd0_o,
  output logic               we1_o,
  output logic [ADDR_W-1:0]  wa1_o,
  output logic [NIB_W-1:0]   wd1_o
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  disp_mode_e        mode_q, mode_d;
  op_e               op;

  assign op = op_e'(frm_byte_i[FRAME_W-1 -: 3]);

  always_comb begin
    ptr_d  = ptr_q;
    mode_d = mode_q;
    we0_o  = 1'b0;
    we1_o  = 1'b0;
    wa0_o  = ptr_q;
    wa1_o  = ptr_step(ptr_q);
    wd0_o  = frm_byte_i[FRAME_W-1 -: NIB_W];
    wd1_o  = frm_byte_i[NIB_W-1:0];
    if (frm_vld_i) begin
      if (!frm_cmd_i) begin
        we0_o = 1'b1;
        we1_o = 1'b1;
        ptr_d = ptr_step(ptr_step(ptr_q));
      end else begin
        unique case (op)
          OP_PTR:  ptr_d  = frm_byte_i[ADDR_W-1:0];
          OP_LIT:  mode_d = MODE_ALL;
          OP_DARK: mode_d = MODE_OFF;
          OP_RUN:  mode_d = MODE_RAM;
          OP_NIB: begin
            we0_o = 1'b1;
            wd0_o = frm_byte_i[NIB_W-1:0];
            ptr_d = ptr_step(ptr_q);
          end
          OP_CLR: begin
            mode_d = MODE_OFF;
            ptr_d  = '0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mode_q <= MODE_OFF;
    end else begin
      ptr_q  <= ptr_d;
      mode_q <= mode_d;
    end
  end

  assign ptr_o  = ptr_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/seg_ram.sv
module seg_ram
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we0_i,
  input  logic [ADDR_W-1:0] wa0_i,
  input  logic [NIB_W-1:0]  wd0_i,
  input  logic              we1_i,
  input  logic [ADDR_W-1:0] wa1_i,
  input  logic [NIB_W-1:0]  wd1_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NIB_W-1:0]  rd_nib_o
);
  logic [NIB_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit0, hit1;
    logic [NIB_W-1:0] ent_d;
    assign hit0 = we0_i && (wa0_i == ADDR_W'(i));
    assign hit1 = we1_i && (wa1_i == ADDR_W'(i));
    always_comb begin
      ent_d = mem_q[i];
      if (hit0)      ent_d = wd0_i;
      else if (hit1) ent_d = wd1_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            mem_q[i] <= '0;
      else if (hit0 || hit1) mem_q[i] <= ent_d;
    end
  end

  always_comb begin
    rd_nib_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_addr_i == ADDR_W'(i)) rd_nib_o = mem_q[i];
    end
  end
endmodule

// File: rtl/seg_cmd_if.sv
module seg_cmd_if
  import seg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_csn,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_cd,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NIB_W-1:0]  rd_nib,
  output logic [1:0]        disp_mode
);
  logic               rst_meta_q, rst_n_s;
  logic [3:0]         pins_s;
  logic               csn_s, sck_s, sdi_s, cd_s;
  logic               frm_vld, frm_cmd;
  logic [FRAME_W-1:0] frm_byte;
  logic [CNT_W-1:0]   bit_cnt;
  logic [ADDR_W-1:0]  cur_ptr;
  disp_mode_e         mode;
  logic               we0, we1;
  logic [ADDR_W-1:0]  wa0, wa1;
  logic [NIB_W-1:0]   wd0, wd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  seg_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   ({ser_csn, ser_clk, ser_dat, ser_cd}),
    .q_o   (pins_s)
  );
  assign {csn_s, sck_s, sdi_s, cd_s} = pins_s;

  seg_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .csn_i      (csn_s),
    .sck_i      (sck_s),
    .sdi_i      (sdi_s),
    .cd_i       (cd_s),
    .frm_vld_o  (frm_vld),
    .frm_cmd_o  (frm_cmd),
    .frm_byte_o (frm_byte),
    .bit_cnt_o  (bit_cnt)
  );

  seg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .frm_vld_i  (frm_vld),
    .frm_cmd_i  (frm_cmd),
    .frm_byte_i (frm_byte),
    .ptr_o      (cur_ptr),
    .mode_o     (mode),
    .we0_o      (we0),
    .wa0_o      (wa0),
    .wd0_o      (wd0),
    .we1_o      (we1),
    .wa1_o      (wa1),
    .wd1_o      (wd1)
  );

  seg_ram u_ram (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .we0_i     (we0),
    .wa0_i     (wa0),
    .wd0_i     (wd0),
    .we1_i     (we1),
    .wa1_i     (wa1),
    .wd1_i     (wd1),
    .rd_addr_i (rd_addr),
    .rd_nib_o  (rd_nib)
  );

  assign disp_mode = mode;
endmodule

// File: rtl/seg_cmd_if_chk.sv
module seg_cmd_if_chk
  import seg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               csn_s,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic               frm_vld,
  input logic               frm_cmd,
  input logic [FRAME_W-1:0] frm_byte,
  input logic [ADDR_W-1:0]  ptr,
  input logic [1:0]         mode
);
  logic [2:0] op;
  logic       is_cmd;
  assign op     = frm_byte[FRAME_W-1 -: 3];
  assign is_cmd = frm_vld && frm_cmd;

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |=> $stable(ptr) && $stable(mode));

  assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && op == 3'b000 |=> ptr == $past(frm_byte[ADDR_W-1:0]));

  assert_data_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld && !frm_cmd && $past(rst_n) && ptr < ADDR_W'(DEPTH - 2) |=> ptr == $past(ptr) + 2);

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && op == 3'b100 && ptr == ADDR_W'(DEPTH - 1) |=> ptr == '0);

  assert_nib_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && op == 3'b100 && ptr < ADDR_W'(DEPTH - 1) |=> ptr == $past(ptr) + 1);

  assert_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  assert_mode_lit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && op == 3'b001 |=> mode == 2'b01);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && op == 3'b110 |=> mode == 2'b00 && ptr == '0);

  assert_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && (op == 3'b101 || op == 3'b111) |=> $stable(ptr) && $stable(mode));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> bit_cnt == '0 && !frm_vld);
endmodule

bind seg_cmd_if seg_cmd_if_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .csn_s    (csn_s),
  .bit_cnt  (bit_cnt),
  .frm_vld  (frm_vld),
  .frm_cmd  (frm_cmd),
  .frm_byte (frm_byte),
  .ptr      (cur_ptr),
  .mode     (disp_mode)
);

// File: tb/tb_seg_cmd_if.sv
module tb_seg_cmd_if;
  logic       clk;
  logic       rst_n;
  logic       ser_csn, ser_clk, ser_dat, ser_cd;
  logic [4:0] rd_addr;
  logic [3:0] rd_nib;
  logic [1:0] disp_mode;

  int n_chk;
  int n_fail;
  bit done;

  logic [3:0] exp_ram [18];
  logic [4:0] exp_ptr;
  logic [1:0] exp_mode;

  seg_cmd_if dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_csn   (ser_csn),
    .ser_clk   (ser_clk),
    .ser_dat   (ser_dat),
    .ser_cd    (ser_cd),
    .rd_addr   (rd_addr),
    .rd_nib    (rd_nib),
    .disp_mode (disp_mode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [4:0] nxt(input logic [4:0] a);
    return (a == 5'd17) ? 5'd0 : a + 5'd1;
  endfunction

  task automatic put(input logic [4:0] a, input logic [3:0] v);
    if (a < 5'd18) exp_ram[a] = v;
  endtask

  task automatic model(input logic [7:0] b, input logic cd);
    if (!cd) begin
      put(exp_ptr, b[7:4]);
      put(nxt(exp_ptr), b[3:0]);
      exp_ptr = nxt(nxt(exp_ptr));
    end else begin
      case (b[7:5])
        3'b000: exp_ptr = b[4:0];
        3'b001: exp_mode = 2'b01;
        3'b010: exp_mode = 2'b00;
        3'b011: exp_mode = 2'b10;
        3'b100: begin put(exp_ptr, b[3:0]); exp_ptr = nxt(exp_ptr); end
        3'b110: begin exp_mode = 2'b00; exp_ptr = 5'd0; end
        default: ;
      endcase
    end
  endtask

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] b, input int n, input logic cd);
    ser_cd  = cd;
    ser_csn = 1'b0;
    waitc(4);
    for (int i = 7; i > 7 - n; i--) begin
      ser_dat = b[i];
      waitc(4);
      ser_clk = 1'b1;
      waitc(4);
      ser_clk = 1'b0;
    end
    waitc(4);
    ser_csn = 1'b1;
    waitc(8);
  endtask

  task automatic send(input logic [7:0] b, input logic cd);
    bits(b, 8, cd);
    model(b, cd);
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 18; a++) begin
      rd_addr = 5'(a);
      #1;
      chk(rd_nib, exp_ram[a], $sformatf("%s entry %0d", tag, a));
    end
    chk({2'b00, disp_mode}, {2'b00, exp_mode}, {tag, " mode"});
  endtask

  task automatic check_one(input int a, input string tag);
    rd_addr = 5'(a);
    #1;
    chk(rd_nib, exp_ram[a], tag);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; ser_csn = 1'b1; ser_clk = 1'b0; ser_dat = 1'b0; ser_cd = 1'b0;
    rd_addr = '0;
    for (int a = 0; a < 18; a++) exp_ram[a] = 4'h0;
    exp_ptr = 5'd0; exp_mode = 2'b00;
    waitc(3);
    rst_n = 1'b1;
    waitc(5);

    check_all("R1 reset");
    rd_addr = 5'd20; #1;
    chk(rd_nib, 4'h0, "R11 out of range read");

    send(8'h60, 1'b1);
    chk({2'b00, disp_mode}, 4'h2, "R7 follow store");
    send(8'h24, 1'b1);
    chk({2'b00, disp_mode}, 4'h1, "R7 all lit");

    send(8'h10, 1'b1);
    send(8'hA5, 1'b0);
    check_one(16, "R4 high nibble at 16");
    check_one(17, "R4 low nibble at 17");
    send(8'h93, 1'b1);
    check_one(0, "R6 pointer wrapped 16+2 to 0");

    send(8'h11, 1'b1);
    send(8'h3C, 1'b0);
    check_one(17, "R6 high nibble at 17");
    check_one(0, "R6 low nibble wraps to 0");
    send(8'h87, 1'b1);
    check_one(1, "R5 nibble lands at 1 after wrap");

    send(8'h42, 1'b1);
    send(8'hA3, 1'b1);
    send(8'hFF, 1'b1);
    chk({2'b00, disp_mode}, 4'h0, "R9 mode after ignored opcodes");
    send(8'h8E, 1'b1);
    check_all("R9 R7 pointer and store after dark and ignored");

    send(8'h05, 1'b1);
    bits(8'hFF, 5, 1'b1);
    send(8'h6B, 1'b0);
    check_all("R10 R2 partial frame discarded");

    send(8'h2A, 1'b1);
    send(8'hC7, 1'b1);
    chk({2'b00, disp_mode}, 4'h0, "R8 clear mode");
    send(8'h89, 1'b1);
    check_all("R8 pointer cleared, store kept");

    rd_addr = 5'd31; #1;
    send(8'h1F, 1'b1);
    send(8'hDD, 1'b0);
    chk(rd_nib, 4'h0, "R11 write past end dropped");

    void'($urandom(32'd1234));
    for (int k = 0; k < 320; k++) begin
      logic [7:0] b;
      logic cd;
      int sel;
      sel = $urandom_range(0, 9);
      b = 8'($urandom);
      cd = 1'b1;
      case (sel)
        0: b = {3'b000, 5'($urandom_range(0, 17))};
        1, 2, 3: cd = 1'b0;
        4, 5: b[7:5] = 3'b100;
        6: b[7:5] = 3'($urandom_range(1, 3));
        7: b[7:5] = ($urandom_range(0, 1) != 0) ? 3'b101 : 3'b111;
        8: b[7:5] = 3'b110;
        default: bits(b, $urandom_range(1, 7), 1'b0);
      endcase
      if (sel != 9) send(b, cd);
      if (k % 40 == 39) check_all("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end
    check_all("R4 R5 final random");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule